// File: doc/BRIEF.md
# Interrupt Redirection Delivery Engine

This engine keeps a pending-request bit for each pin in a bank of interrupt inputs. Whenever a pending request is deliverable, it turns that request into a message-signalled interrupt write: a 32-bit address word and a 32-bit data word. A table of 64-bit redirection entries arrives as a flat input vector, one entry per pin. Each entry sets how its pin behaves: the vector, the delivery mode, the destination and destination mode, the mask, and whether the pin is edge or level triggered. Reading and writing that table belongs to the surrounding logic.

Input events arrive one per cycle as a pin number and a level. Level pins track the level of their input. When a level request is delivered, the engine sets a remote-pending bit, and it sends no further message for that pin until an end-of-interrupt (EOI) broadcast clears the bit. An EOI carries a vector and clears the bit only where that vector matches. Edge pins latch a rising request only while unmasked, and the request is dropped once it has been delivered. Messages leave through a valid/ready port, one at a time, and the remote-pending bits are driven out for the register file to show.

Top module: `irq_redir_engine`

## Requirements
- R1: After reset no message is offered (`msg_valid` = 0) and every `remote_pend` bit is 0.
- R2: An event on input number 0 acts on pin 2. Every other number n below NPINS (24) acts on pin n. Numbers of NPINS and above are ignored, and pin 0 cannot be reached.
- R3: For a level pin (entry bit 15 = 1), an event with `in_level` = 1 sets its request and `in_level` = 0 clears it. If the entry is unmasked (bit 16 = 0) and its remote-pending bit is clear, the request produces one message and sets `remote_pend` for that pin.
- R4: While a level pin's remote-pending bit is set, re-asserting its input sends no further message.
- R5: For an edge pin (bit 15 = 0), a rising event (`in_level` = 1) is latched only when the entry is unmasked. An event that arrives while masked is lost and yields no message after unmasking.
- R6: Masked entries are passed over during the scan but keep their request. A level request held while masked is delivered once the mask is cleared.
- R7: When several pins are deliverable, the lowest-numbered pin is issued first.
- R8: Delivering an edge request clears it, so one rising event yields exactly one message.
- R9: An EOI with vector V clears the remote-pending bit of every entry whose bit is set and whose vector (bits 7:0) equals V. Other entries are unchanged. If the cleared pin is unmasked and its request is still set, it is delivered again.
- R10: The address word is 0xFEE00000 OR'ed with the destination (entry bits 63:48) placed at address bits 27:12 and the destination mode (entry bit 11) placed at address bit 2.
- R11: The data word carries the vector in bits 7:0, the delivery mode (entry bits 10:8) in bits 10:8 and the trigger bit in bit 15. All other data bits are 0.
- R12: A message offered with `msg_ready` low stays valid with unchanged address and data. After each accepted message the scan resumes with the next deliverable pin.
- R13: The remote-pending bit of a pin whose entry is edge triggered is forced to 0.
- R14: A rising edge event that arrives in the same cycle as its pin's pending request is taken for delivery is kept, and it yields a second message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_table | input | NPINS*64 | Redirection entries, entry i at bits 64*i+63 : 64*i |
| in_valid | input | 1 | Input event strobe |
| in_num | input | IN_W | Input number of the event |
| in_level | input | 1 | New level of the input (1 = asserted / rising) |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector carried by the EOI |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Receiver accepts the offered message |
| msg_addr | output | 32 | Message address word |
| msg_data | output | 32 | Message data word |
| remote_pend | output | NPINS | Remote-pending bit of each pin |

## Verification
Two functions can act on the same request bit in the same cycle. Taking an edge pin's request for delivery clears it, while a fresh rising event on that pin sets it. The bench provokes this by driving two rising events on one edge pin in back-to-back cycles, so the second event is sampled on the edge that loads the first. The result counts as correct only if the scoreboard receives exactly two identical messages for that pin and nothing is left over. The collision between EOI and delivery is also exercised: an EOI arrives while a level input is still asserted, and the bench expects a fresh message and a re-set remote-pending bit.

// File: rtl/redir_pkg.sv
package redir_pkg;

  localparam int ENT_W       = 64;
  localparam int VEC_W       = 8;

  // entry field positions (consumed by neighbouring register logic)
  localparam int F_VEC_LO    = 0;
  localparam int F_DLV_LO    = 8;
  localparam int F_DMODE     = 11;
  localparam int F_TRIG      = 15;
  localparam int F_MASK      = 16;
  localparam int F_DEST_LO   = 48;

  localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;
  localparam int A_DEST_LO   = 12;
  localparam int A_DMODE     = 2;
  localparam int D_DLV_LO    = 8;
  localparam int D_TRIG      = 15;

  function automatic logic [VEC_W-1:0] ent_vector(input logic [ENT_W-1:0] e);
    return e[F_VEC_LO +: VEC_W];
  endfunction

  function automatic logic ent_trig(input logic [ENT_W-1:0] e);
    return e[F_TRIG];
  endfunction

  function automatic logic ent_mask(input logic [ENT_W-1:0] e);
    return e[F_MASK];
  endfunction

  function automatic logic [31:0] form_addr(input logic [ENT_W-1:0] e);
    logic [31:0] a;
    a = MSG_BASE;
    a[A_DEST_LO +: 16] = a[A_DEST_LO +: 16] | e[F_DEST_LO +: 16];
    a[A_DMODE]         = a[A_DMODE] | e[F_DMODE];
    return a;
  endfunction

  function automatic logic [31:0] form_data(input logic [ENT_W-1:0] e);
    logic [31:0] d;
    d = '0;
    d[0 +: VEC_W]     = e[F_VEC_LO +: VEC_W];
    d[D_DLV_LO +: 3]  = e[F_DLV_LO +: 3];
    d[D_TRIG]         = e[F_TRIG];
    return d;
  endfunction

endpackage

// File: rtl/redir_req_bank.sv
module redir_req_bank #(
  parameter int NPINS = 24,
  parameter int IN_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_num,
  input  logic             in_level,
  input  logic [NPINS-1:0] trig_vec,
  input  logic [NPINS-1:0] mask_vec,
  input  logic [NPINS-1:0] served_vec,
  output logic [NPINS-1:0] req_vec
);

  localparam int REDIR_PIN = 2;

  logic [IN_W-1:0] mapped;
  logic            hit;

  always_comb begin
    mapped = (in_num == '0) ? IN_W'(REDIR_PIN) : in_num;
    hit    = in_valid && (int'(mapped) < NPINS);
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic here, set_i, clr_i;
    always_comb begin
      here  = hit && (int'(mapped) == i);
      set_i = here && in_level && (trig_vec[i] || !mask_vec[i]);
      clr_i = (here && trig_vec[i] && !in_level) ||
              (served_vec[i] && !trig_vec[i]);
    end
    always_ff @(posedge clk) begin
      if (!rst_n)     req_vec[i] <= 1'b0;
      else if (set_i) req_vec[i] <= 1'b1;   // fresh arrival wins over delivery
      else if (clr_i) req_vec[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/redir_remote_bank.sv
module redir_remote_bank #(
  parameter int NPINS = 24,
  parameter int VEC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPINS-1:0]       trig_vec,
  input  logic [NPINS*VEC_W-1:0] vec_flat,
  input  logic [NPINS-1:0]       served_vec,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  output logic [NPINS-1:0]       rpend_vec
);

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic eoi_hit;
    assign eoi_hit = eoi_valid && rpend_vec[i] &&
                     (vec_flat[i*VEC_W +: VEC_W] == eoi_vector);
    always_ff @(posedge clk) begin
      if (!rst_n)               rpend_vec[i] <= 1'b0;
      else if (!trig_vec[i])    rpend_vec[i] <= 1'b0;
      else if (served_vec[i])   rpend_vec[i] <= 1'b1;
      else if (eoi_hit)         rpend_vec[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/redir_arbiter.sv
module redir_arbiter #(
  parameter int NPINS = 24,
  localparam int PIN_W = $clog2(NPINS)
) (
  input  logic [NPINS-1:0] cand_vec,
  output logic [NPINS-1:0] grant_vec,
  output logic [PIN_W-1:0] grant_idx,
  output logic             any_cand
);

  logic [NPINS:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < NPINS; i++) begin : g_chain
    assign seen[i+1]    = seen[i] | cand_vec[i];
    assign grant_vec[i] = cand_vec[i] & ~seen[i];
  end

  assign any_cand = seen[NPINS];

  always_comb begin
    grant_idx = '0;
    for (int i = 0; i < NPINS; i++)
      if (grant_vec[i]) grant_idx = PIN_W'(i);
  end

endmodule

// File: rtl/irq_redir_engine.sv
module irq_redir_engine
  import redir_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IN_W  = 5,
  localparam int PIN_W = $clog2(NPINS),
  localparam int TBL_W = NPINS * ENT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TBL_W-1:0] cfg_table,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_num,
  input  logic             in_level,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vector,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [31:0]      msg_addr,
  output logic [31:0]      msg_data,
  output logic [NPINS-1:0] remote_pend
);

  logic [NPINS-1:0]       trig_vec, mask_vec, req_vec, cand_vec;
  logic [NPINS-1:0]       grant_vec, served_vec;
  logic [NPINS*VEC_W-1:0] vec_flat;
  logic [PIN_W-1:0]       grant_idx;
  logic                   any_cand, load_evt;
  logic [ENT_W-1:0]       sel_entry;

  for (genvar i = 0; i < NPINS; i++) begin : g_unpack
    assign trig_vec[i]              = ent_trig(cfg_table[i*ENT_W +: ENT_W]);
    assign mask_vec[i]              = ent_mask(cfg_table[i*ENT_W +: ENT_W]);
    assign vec_flat[i*VEC_W +: VEC_W] = ent_vector(cfg_table[i*ENT_W +: ENT_W]);
  end

  redir_req_bank #(.NPINS(NPINS), .IN_W(IN_W)) u_req (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_num(in_num), .in_level(in_level),
    .trig_vec(trig_vec), .mask_vec(mask_vec), .served_vec(served_vec),
    .req_vec(req_vec)
  );

  redir_remote_bank #(.NPINS(NPINS), .VEC_W(VEC_W)) u_rpend (
    .clk(clk), .rst_n(rst_n),
    .trig_vec(trig_vec), .vec_flat(vec_flat), .served_vec(served_vec),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .rpend_vec(remote_pend)
  );

  // deliverable: requested, unmasked, and (edge or no remote pending)
  assign cand_vec = req_vec & ~mask_vec & (~trig_vec | ~remote_pend);

  redir_arbiter #(.NPINS(NPINS)) u_arb (
    .cand_vec(cand_vec), .grant_vec(grant_vec),
    .grant_idx(grant_idx), .any_cand(any_cand)
  );

  assign load_evt   = any_cand && (!msg_valid || msg_ready);
  assign served_vec = grant_vec & {NPINS{load_evt}};
  assign sel_entry  = cfg_table[int'(grant_idx)*ENT_W +: ENT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
    end else if (load_evt) begin
      msg_valid <= 1'b1;
      msg_addr  <= form_addr(sel_entry);
      msg_data  <= form_data(sel_entry);
    end else if (msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_redir_engine_chk.sv
module irq_redir_engine_chk #(
  parameter int NPINS = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input logic [31:0]      msg_addr,
  input logic [31:0]      msg_data,
  input logic [NPINS-1:0] remote_pend,
  input logic [NPINS-1:0] trig_vec,
  input logic [NPINS-1:0] mask_vec,
  input logic [NPINS-1:0] grant_vec,
  input logic             load_evt
);

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R12

  AST_NO_MASKED_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> (grant_vec & mask_vec) == '0); // R6

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec)); // R7

  AST_RPEND_RISE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (remote_pend & ~$past(remote_pend)) != '0 |-> $past(load_evt)); // R3

  AST_EDGE_NO_RPEND: assert property (@(posedge clk) disable iff (!rst_n)
    trig_vec != '1 |=> (remote_pend & ~$past(trig_vec)) == '0); // R13

  AST_ADDR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr[31:28] == 4'hF && msg_addr[11:3] == '0 && msg_addr[1:0] == '0); // R10

  AST_DATA_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_data[31:16] == '0 && msg_data[14:11] == '0); // R11

endmodule

bind irq_redir_engine irq_redir_engine_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data), .remote_pend(remote_pend),
  .trig_vec(trig_vec), .mask_vec(mask_vec), .grant_vec(grant_vec),
  .load_evt(load_evt)
);

// File: tb/irq_redir_engine_tb.sv
module irq_redir_engine_tb;

  localparam int NP = 24;
  localparam int IW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP*64-1:0] cfg_table;
  logic            in_valid = 1'b0;
  logic [IW-1:0]   in_num = '0;
  logic            in_level = 1'b0;
  logic            eoi_valid = 1'b0;
  logic [7:0]      eoi_vector = '0;
  logic            msg_valid;
  logic            msg_ready = 1'b1;
  logic [31:0]     msg_addr, msg_data;
  logic [NP-1:0]   remote_pend;

  logic [63:0] cfg [NP];
  logic [63:0] exp_q [$];
  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;   // 125 MHz

  always_comb
    for (int i = 0; i < NP; i++) cfg_table[i*64 +: 64] = cfg[i];

  irq_redir_engine #(.NPINS(NP), .IN_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_table(cfg_table),
    .in_valid(in_valid), .in_num(in_num), .in_level(in_level),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data), .remote_pend(remote_pend)
  );

  function automatic logic [63:0] mk(int pin, bit lvl, bit msk, logic [7:0] vec);
    logic [63:0] e = '0;
    e[7:0]   = vec;
    e[10:8]  = 3'(pin % 8);
    e[11]    = pin[0];
    e[15]    = lvl;
    e[16]    = msk;
    e[63:48] = 16'(16'h1000 + pin * 17);
    return e;
  endfunction

  function automatic logic [31:0] x_addr(logic [63:0] e);
    return 32'hFEE0_0000 | ({16'h0, e[63:48]} << 12) | {29'h0, e[11], 2'b00};
  endfunction

  function automatic logic [31:0] x_data(logic [63:0] e);
    return {16'h0, e[15], 4'h0, e[10:8], e[7:0]};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each accepted message
  always @(negedge clk) begin
    if (rst_n && msg_valid && msg_ready) begin
      if (exp_q.size() == 0) begin
        check(0, "R2/R4/R5/R8 unexpected message", {msg_addr, msg_data}, 64'h0);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check(msg_addr == x_addr(e), "R10 address", msg_addr, x_addr(e));
        check(msg_data == x_data(e), "R11 data",    msg_data, x_data(e));
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(int num, bit lvl);
    in_valid = 1'b1; in_num = IW'(num); in_level = lvl;
    step(1);
    in_valid = 1'b0;
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_valid = 1'b1; eoi_vector = v;
    step(1);
    eoi_valid = 1'b0;
  endtask

  task automatic drained(string tag);
    step(6);
    check(exp_q.size() == 0, tag, 64'(exp_q.size()), 64'h0);
  endtask

  initial begin
    #(8 * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NP; i++) cfg[i] = mk(i, 0, 1, 8'(8'h30 + i));
    step(3);
    @(negedge clk);
    check(msg_valid == 1'b0, "R1 msg_valid at reset", 64'(msg_valid), 64'h0);
    check(remote_pend == '0, "R1 remote_pend at reset", 64'(remote_pend), 64'h0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    step(2);

    // R8: one edge event, one message
    cfg[5] = mk(5, 0, 0, 8'h35);
    exp_q.push_back(cfg[5]);
    pulse(5, 1);
    drained("R8 edge single delivery");

    // R2: input 0 goes to pin 2, out-of-range ignored
    cfg[0] = mk(0, 0, 0, 8'h30);
    cfg[2] = mk(2, 0, 0, 8'h32);
    exp_q.push_back(cfg[2]);
    pulse(0, 1);
    pulse(24, 1);
    pulse(31, 1);
    drained("R2 mapping and range");

    // R5: masked edge dropped
    pulse(7, 1);
    step(2);
    cfg[7] = mk(7, 0, 0, 8'h37);
    drained("R5 masked edge dropped");

    // R3 / R4 / R9: level pin 9
    cfg[9] = mk(9, 1, 0, 8'h49);
    exp_q.push_back(cfg[9]);
    pulse(9, 1);
    drained("R3 level delivery");
    check(remote_pend[9] == 1'b1, "R3 remote_pend set", 64'(remote_pend), 64'h200);
    pulse(9, 0);
    pulse(9, 1);
    drained("R4 coalesced while pending");
    exp_q.push_back(cfg[9]);
    eoi(8'h49);
    drained("R9 re-delivery after EOI");
    check(remote_pend[9] == 1'b1, "R9 remote_pend set again", 64'(remote_pend), 64'h200);
    pulse(9, 0);
    eoi(8'h49);
    step(2);
    check(remote_pend[9] == 1'b0, "R9 EOI clears", 64'(remote_pend), 64'h0);
    drained("R9 no message without request");

    // R9: non-matching vector leaves bit
    cfg[10] = mk(10, 1, 0, 8'h50);
    exp_q.push_back(cfg[10]);
    pulse(10, 1);
    pulse(10, 0);
    eoi(8'h51);
    step(2);
    check(remote_pend[10] == 1'b1, "R9 mismatched EOI", 64'(remote_pend[10]), 64'h1);
    eoi(8'h50);
    step(2);
    check(remote_pend[10] == 1'b0, "R9 matched EOI", 64'(remote_pend[10]), 64'h0);
    drained("R9 pin 10 messages");

    // R13: switching to edge clears remote pending
    cfg[11] = mk(11, 1, 0, 8'h51);
    exp_q.push_back(cfg[11]);
    pulse(11, 1);
    pulse(11, 0);
    step(2);
    check(remote_pend[11] == 1'b1, "R13 level pend before", 64'(remote_pend[11]), 64'h1);
    cfg[11] = mk(11, 0, 0, 8'h51);
    step(2);
    check(remote_pend[11] == 1'b0, "R13 edge forces clear", 64'(remote_pend[11]), 64'h0);
    drained("R13 messages");

    // R6: masked level keeps its request
    cfg[12] = mk(12, 1, 1, 8'h52);
    pulse(12, 1);
    step(3);
    check(remote_pend[12] == 1'b0, "R6 masked not serviced", 64'(remote_pend[12]), 64'h0);
    drained("R6 no message while masked");
    exp_q.push_back(mk(12, 1, 0, 8'h52));
    cfg[12] = mk(12, 1, 0, 8'h52);
    drained("R6 delivered after unmask");
    pulse(12, 0);
    eoi(8'h52);

    // R7 / R12: ordering and hold under back-pressure
    cfg[20] = mk(20, 0, 0, 8'h60);
    cfg[14] = mk(14, 0, 0, 8'h54);
    cfg[3]  = mk(3, 0, 0, 8'h33);
    exp_q.push_back(cfg[20]);
    exp_q.push_back(cfg[3]);
    exp_q.push_back(cfg[14]);
    msg_ready = 1'b0;
    pulse(20, 1);
    pulse(14, 1);
    pulse(3, 1);
    step(2);
    @(negedge clk);
    check(msg_valid && msg_addr == x_addr(cfg[20]), "R12 held message",
          64'(msg_addr), 64'(x_addr(cfg[20])));
    step(3);
    check(msg_valid && msg_data == x_data(cfg[20]), "R12 still held",
          64'(msg_data), 64'(x_data(cfg[20])));
    msg_ready = 1'b1;
    drained("R7 ascending order");

    // R14: arrival in the delivery cycle is kept
    cfg[15] = mk(15, 0, 0, 8'h55);
    exp_q.push_back(cfg[15]);
    exp_q.push_back(cfg[15]);
    in_valid = 1'b1; in_num = 5'd15; in_level = 1'b1;
    step(2);
    in_valid = 1'b0;
    drained("R14 same-cycle arrival");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule